// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits on the controller side of a four-bank DDR SDRAM and drives its command pins: chip select, the three strobes RAS#, CAS# and WE#, the bank address and the address bus. Out of reset it brings the memory up by itself. It waits a set number of cycles, precharges every bank, switches the DLL on through the extended mode register, and programs burst length and CAS latency into the base mode register. It then issues two auto refreshes and raises `init_done`.

After initialization a client hands it one request at a time on a valid/ready handshake. Each request is an activate, read, write, precharge or auto refresh for a bank. The sequencer tracks which banks hold an open row. It holds `req_ready` low while a request would break bank state or a minimum command spacing, so every accepted request reaches the pins on the next clock edge. Minimum spacings are parameters in clock cycles. Every cycle that carries no command shows a NOP.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While `rst_n` is low the pins show a deselect (`cmd_cs_n`=1, strobes high, bank and address zero), and `init_done` and `req_ready` are 0. From the first clock edge after reset, `cmd_cs_n` stays 0.
- R2: Initialization runs in this order. First come INIT_WAIT NOP cycles. Then precharge-all, extended mode load, base mode load and auto refresh twice. `init_done` rises on the edge that issues the second refresh.
- R3: Pin encodings as (RAS#,CAS#,WE#) are as follows: NOP 111, ACTIVE 011, AUTO REFRESH 001, PRECHARGE 010, READ 101, WRITE 100, mode load 000. Bank address 01 selects the extended word, which is all zero so that bit 0 = 0 turns the DLL on. Bank address 00 selects the base word, with burst code in bits [2:0] (2→001, 4→010, 8→011) and CAS latency in bits [6:4] (2→010, 2.5→110, 3→011).
- R4: Two mode loads are at least T_MRD cycles apart, and an auto refresh comes at least T_MRD cycles after a mode load.
- R5: An auto refresh or an activate comes at least T_RP cycles after the last precharge, counting precharge-all, single-bank precharge and reads or writes with auto-precharge.
- R6: An auto refresh or an activate comes at least T_RC cycles after the last auto refresh.
- R7: A read or write comes at least T_RCD cycles after the last activate.
- R8: Activate is accepted only for a bank with no open row. Read and write are accepted only for a bank with an open row. Activate puts the request address on the pins.
- R9: Auto refresh is accepted only when no bank has an open row.
- R10: On read and write, address bit 10 carries `req_autopre`, and a set bit closes that bank. A precharge with `req_autopre`=1 drives address 0x400 and closes every bank. With 0 it drives address 0 and closes only `req_bank`.
- R11: Request op codes are 0 activate, 1 read, 2 write, 3 precharge and 4 refresh. Codes 5 to 7 are never accepted. An accepted request appears on the pins on the next clock edge.
- R12: `req_ready` is 0 until `init_done` is 1, and a request offered before then leaves the pins at the initialization sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_op | input | 3 | Request code (R11) |
| req_bank | input | BA_W | Target bank |
| req_addr | input | ADDR_W | Row for activate, column for read/write |
| req_autopre | input | 1 | Auto-precharge on read/write; all banks on precharge |
| req_ready | output | 1 | Request accepted this cycle when valid |
| init_done | output | 1 | Power-up sequence complete |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe |
| cmd_cas_n | output | 1 | Column strobe |
| cmd_we_n | output | 1 | Write enable |
| cmd_ba | output | BA_W | Bank address |
| cmd_addr | output | ADDR_W | Address bus |

## Verification
The assertions read only the command pins. They assume that nothing but this block drives those pins and that reset is held for at least one edge. Under those assumptions, the bank-state and spacing checks can rebuild bank state and gaps from the pins alone. The stimulus offers requests only through the handshake. It keeps each request steady until it is accepted or withdrawn on a falling edge. It deliberately offers illegal requests: an activate to an open bank, a read to a closed bank, a refresh with a row open, and an unused op code. Each is held for several cycles to show it is never issued.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

   typedef struct packed {
      logic ras_n;
      logic cas_n;
      logic we_n;
   } pin_cmd_t;

   localparam pin_cmd_t PC_NOP = 3'b111;
   localparam pin_cmd_t PC_ACT = 3'b011;
   localparam pin_cmd_t PC_REF = 3'b001;
   localparam pin_cmd_t PC_PRE = 3'b010;
   localparam pin_cmd_t PC_RD  = 3'b101;
   localparam pin_cmd_t PC_WR  = 3'b100;
   localparam pin_cmd_t PC_MRS = 3'b000;

   localparam logic [2:0] OP_ACT = 3'd0;
   localparam logic [2:0] OP_RD  = 3'd1;
   localparam logic [2:0] OP_WR  = 3'd2;
   localparam logic [2:0] OP_PRE = 3'd3;
   localparam logic [2:0] OP_REF = 3'd4;

   typedef enum logic [2:0] {
      ST_WAIT, ST_EMR, ST_MR, ST_REF1, ST_REF2, ST_RUN
   } seq_state_e;

endpackage

// File: rtl/ddr_gap_timer.sv
module ddr_gap_timer #(
   parameter int unsigned GAP = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic idle
);
   localparam int unsigned W      = (GAP > 1) ? $clog2(GAP + 1) : 1;
   localparam int unsigned LOAD_I = (GAP > 1) ? GAP - 1 : 0;
   localparam logic [W-1:0] LOAD_V = LOAD_I[W-1:0];

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= LOAD_V;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign idle = (cnt_q == '0);
endmodule

// File: rtl/ddr_mode_word.sv
module ddr_mode_word #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned BURST_LEN = 4,
   parameter int unsigned CL_HALF   = 5
) (
   output logic [ADDR_W-1:0] base_word,
   output logic [ADDR_W-1:0] ext_word
);
   localparam logic [2:0] BL_CODE = (BURST_LEN == 2) ? 3'b001 :
                                    (BURST_LEN == 4) ? 3'b010 :
                                    (BURST_LEN == 8) ? 3'b011 : 3'b000;
   localparam logic [2:0] CL_CODE = (CL_HALF == 4) ? 3'b010 :
                                    (CL_HALF == 5) ? 3'b110 :
                                    (CL_HALF == 6) ? 3'b011 : 3'b000;

   generate
      if (BL_CODE == 3'b000) begin : g_bad_bl
         $error("ddr_mode_word: BURST_LEN must be 2, 4 or 8");
      end
      if (CL_CODE == 3'b000) begin : g_bad_cl
         $error("ddr_mode_word: CL_HALF must be 4, 5 or 6");
      end
      if (ADDR_W < 11) begin : g_bad_aw
         $error("ddr_mode_word: ADDR_W must be at least 11");
      end
   endgenerate

   always_comb begin
      base_word      = '0;
      base_word[2:0] = BL_CODE;
      base_word[6:4] = CL_CODE;
      ext_word       = '0;
   end
endmodule

// File: rtl/ddr_bank_state.sv
module ddr_bank_state #(
   parameter int unsigned BA_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_en,
   input  logic              close_en,
   input  logic              close_all,
   input  logic [BA_W-1:0]   bank,
   output logic [(1<<BA_W)-1:0] open_mask
);
   localparam int unsigned NBANK = 1 << BA_W;

   generate
      for (genvar g = 0; g < NBANK; g++) begin : g_bank
         localparam logic [BA_W-1:0] ID = g[BA_W-1:0];
         always_ff @(posedge clk) begin
            if (!rst_n)
               open_mask[g] <= 1'b0;
            else if (close_all || (close_en && bank == ID))
               open_mask[g] <= 1'b0;
            else if (open_en && bank == ID)
               open_mask[g] <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
   import ddr_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned BA_W      = 2,
   parameter int unsigned BURST_LEN = 4,
   parameter int unsigned CL_HALF   = 5,
   parameter int unsigned INIT_WAIT = 4,
   parameter int unsigned T_MRD     = 2,
   parameter int unsigned T_RP      = 3,
   parameter int unsigned T_RC      = 7,
   parameter int unsigned T_RCD     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [BA_W-1:0]   req_bank,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_autopre,
   output logic              req_ready,
   output logic              init_done,
   output logic              cmd_cs_n,
   output logic              cmd_ras_n,
   output logic              cmd_cas_n,
   output logic              cmd_we_n,
   output logic [BA_W-1:0]   cmd_ba,
   output logic [ADDR_W-1:0] cmd_addr
);
   localparam int unsigned NBANK  = 1 << BA_W;
   localparam int unsigned WAIT_W = (INIT_WAIT > 0) ? $clog2(INIT_WAIT + 1) : 1;
   localparam logic [WAIT_W-1:0] WAIT_V = INIT_WAIT[WAIT_W-1:0];

   generate
      if (BA_W != 2) begin : g_bad_ba
         $error("ddr_cmd_seq: the device has four banks, BA_W must be 2");
      end
   endgenerate

   seq_state_e        st_q, st_d;
   logic [WAIT_W-1:0] wait_q;
   pin_cmd_t          pins_q, pins_d;
   logic [BA_W-1:0]   ba_q, ba_d;
   logic [ADDR_W-1:0] addr_q, addr_d;
   logic              cs_q, done_q;

   logic ld_mrd, ld_rp, ld_rc, ld_rcd;
   logic mrd_idle, rp_idle, rc_idle, rcd_idle;
   logic open_en, close_en, close_all;
   logic [NBANK-1:0]  open_mask;
   logic [ADDR_W-1:0] base_word, ext_word;
   logic              accept_ok;

   ddr_mode_word #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN), .CL_HALF(CL_HALF))
      u_words (.base_word(base_word), .ext_word(ext_word));

   ddr_gap_timer #(.GAP(T_MRD)) u_mrd (.clk(clk), .rst_n(rst_n), .load(ld_mrd), .idle(mrd_idle));
   ddr_gap_timer #(.GAP(T_RP))  u_rp  (.clk(clk), .rst_n(rst_n), .load(ld_rp),  .idle(rp_idle));
   ddr_gap_timer #(.GAP(T_RC))  u_rc  (.clk(clk), .rst_n(rst_n), .load(ld_rc),  .idle(rc_idle));
   ddr_gap_timer #(.GAP(T_RCD)) u_rcd (.clk(clk), .rst_n(rst_n), .load(ld_rcd), .idle(rcd_idle));

   ddr_bank_state #(.BA_W(BA_W)) u_banks (
      .clk(clk), .rst_n(rst_n), .open_en(open_en), .close_en(close_en),
      .close_all(close_all), .bank(req_bank), .open_mask(open_mask));

   // request legality in the running state
   always_comb begin
      case (req_op)
         OP_ACT:        accept_ok = !open_mask[req_bank] && rc_idle && rp_idle;
         OP_RD, OP_WR:  accept_ok = open_mask[req_bank] && rcd_idle;
         OP_PRE:        accept_ok = 1'b1;
         OP_REF:        accept_ok = (open_mask == '0) && rc_idle && rp_idle && mrd_idle;
         default:       accept_ok = 1'b0;
      endcase
   end

   always_comb begin
      st_d      = st_q;
      pins_d    = PC_NOP;
      ba_d      = '0;
      addr_d    = '0;
      ld_mrd    = 1'b0;
      ld_rp     = 1'b0;
      ld_rc     = 1'b0;
      ld_rcd    = 1'b0;
      open_en   = 1'b0;
      close_en  = 1'b0;
      close_all = 1'b0;
      req_ready = 1'b0;
      unique case (st_q)
         ST_WAIT: if (wait_q == '0) begin
            pins_d     = PC_PRE;
            addr_d[10] = 1'b1;
            ld_rp      = 1'b1;
            close_all  = 1'b1;
            st_d       = ST_EMR;
         end
         ST_EMR: if (rp_idle && mrd_idle) begin
            pins_d = PC_MRS;
            ba_d   = BA_W'(1);
            addr_d = ext_word;
            ld_mrd = 1'b1;
            st_d   = ST_MR;
         end
         ST_MR: if (mrd_idle) begin
            pins_d = PC_MRS;
            addr_d = base_word;
            ld_mrd = 1'b1;
            st_d   = ST_REF1;
         end
         ST_REF1: if (rp_idle && mrd_idle && rc_idle) begin
            pins_d = PC_REF;
            ld_rc  = 1'b1;
            st_d   = ST_REF2;
         end
         ST_REF2: if (rc_idle) begin
            pins_d = PC_REF;
            ld_rc  = 1'b1;
            st_d   = ST_RUN;
         end
         ST_RUN: begin
            req_ready = accept_ok;
            if (req_valid && accept_ok) begin
               case (req_op)
                  OP_ACT: begin
                     pins_d  = PC_ACT;
                     ba_d    = req_bank;
                     addr_d  = req_addr;
                     open_en = 1'b1;
                     ld_rcd  = 1'b1;
                  end
                  OP_RD, OP_WR: begin
                     pins_d     = (req_op == OP_RD) ? PC_RD : PC_WR;
                     ba_d       = req_bank;
                     addr_d     = req_addr;
                     addr_d[10] = req_autopre;
                     close_en   = req_autopre;
                     ld_rp      = req_autopre;
                  end
                  OP_PRE: begin
                     pins_d     = PC_PRE;
                     ba_d       = req_bank;
                     addr_d[10] = req_autopre;
                     close_all  = req_autopre;
                     close_en   = !req_autopre;
                     ld_rp      = 1'b1;
                  end
                  default: begin
                     pins_d = PC_REF;
                     ld_rc  = 1'b1;
                  end
               endcase
            end
         end
         default: st_d = ST_WAIT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_WAIT;
         wait_q <= WAIT_V;
         pins_q <= PC_NOP;
         ba_q   <= '0;
         addr_q <= '0;
         cs_q   <= 1'b1;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         if (st_q == ST_WAIT && wait_q != '0) wait_q <= wait_q - 1'b1;
         pins_q <= pins_d;
         ba_q   <= ba_d;
         addr_q <= addr_d;
         cs_q   <= 1'b0;
         done_q <= (st_d == ST_RUN);
      end
   end

   assign init_done = done_q;
   assign cmd_cs_n  = cs_q;
   assign cmd_ras_n = pins_q.ras_n;
   assign cmd_cas_n = pins_q.cas_n;
   assign cmd_we_n  = pins_q.we_n;
   assign cmd_ba    = ba_q;
   assign cmd_addr  = addr_q;
endmodule

// File: rtl/ddr_cmd_seq_chk.sv
module ddr_cmd_seq_chk #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned BA_W   = 2,
   parameter int unsigned T_MRD  = 2,
   parameter int unsigned T_RP   = 3,
   parameter int unsigned T_RC   = 7,
   parameter int unsigned T_RCD  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              init_done,
   input logic              cmd_cs_n,
   input logic              cmd_ras_n,
   input logic              cmd_cas_n,
   input logic              cmd_we_n,
   input logic [BA_W-1:0]   cmd_ba,
   input logic [ADDR_W-1:0] cmd_addr
);
   localparam int unsigned NBANK = 1 << BA_W;
   logic [2:0] p;
   assign p = {cmd_ras_n, cmd_cas_n, cmd_we_n};

   logic is_act, is_ref, is_mrs, is_rw, is_pre_evt;
   assign is_act     = !cmd_cs_n && p == 3'b011;
   assign is_ref     = !cmd_cs_n && p == 3'b001;
   assign is_mrs     = !cmd_cs_n && p == 3'b000;
   assign is_rw      = !cmd_cs_n && (p == 3'b101 || p == 3'b100);
   assign is_pre_evt = !cmd_cs_n && (p == 3'b010 || (is_rw && cmd_addr[10]));

   logic [15:0] gap_mrd, gap_rp, gap_rc, gap_rcd;
   logic [NBANK-1:0] shadow_open;

   function automatic logic [15:0] bump(input logic [15:0] v);
      return (v == 16'hFFFF) ? v : v + 16'd1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_mrd <= 16'hFFFF; gap_rp <= 16'hFFFF;
         gap_rc  <= 16'hFFFF; gap_rcd <= 16'hFFFF;
         shadow_open <= '0;
      end else begin
         gap_mrd <= is_mrs     ? 16'd1 : bump(gap_mrd);
         gap_rp  <= is_pre_evt ? 16'd1 : bump(gap_rp);
         gap_rc  <= is_ref     ? 16'd1 : bump(gap_rc);
         gap_rcd <= is_act     ? 16'd1 : bump(gap_rcd);
         if (is_act) shadow_open[cmd_ba] <= 1'b1;
         else if (!cmd_cs_n && p == 3'b010 && cmd_addr[10]) shadow_open <= '0;
         else if (is_pre_evt) shadow_open[cmd_ba] <= 1'b0;
      end
   end

   assert_mrd_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mrs || is_ref) |-> gap_mrd >= T_MRD);
   assert_rp_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ref || is_act) |-> gap_rp >= T_RP);
   assert_rc_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ref || is_act) |-> gap_rc >= T_RC);
   assert_rcd_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      is_rw |-> gap_rcd >= T_RCD);
   assert_rw_open_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      is_rw |-> shadow_open[cmd_ba]);
   assert_act_closed_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> !shadow_open[cmd_ba]);
   assert_ref_all_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ref || is_mrs) |-> shadow_open == '0);
   assert_no_ready_early_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> !req_ready);
   assert_no_access_early_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> !(is_act || is_rw));
endmodule

bind ddr_cmd_seq ddr_cmd_seq_chk #(
   .ADDR_W(ADDR_W), .BA_W(BA_W), .T_MRD(T_MRD), .T_RP(T_RP), .T_RC(T_RC), .T_RCD(T_RCD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .init_done(init_done),
   .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
   .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr)
);

// File: tb/ddr_cmd_seq_test.sv
module ddr_cmd_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 12, BW = 2, BL = 4, CLH = 5, IW = 4;
   localparam int TMRD = 2, TRP = 3, TRC = 7, TRCD = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_autopre = 1'b0;
   logic [2:0] req_op = 3'd0;
   logic [BW-1:0] req_bank = '0;
   logic [AW-1:0] req_addr = '0;
   logic req_ready, init_done, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
   logic [BW-1:0] cmd_ba;
   logic [AW-1:0] cmd_addr;

   ddr_cmd_seq #(.ADDR_W(AW), .BA_W(BW), .BURST_LEN(BL), .CL_HALF(CLH), .INIT_WAIT(IW),
      .T_MRD(TMRD), .T_RP(TRP), .T_RC(TRC), .T_RCD(TRCD)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_bank(req_bank), .req_addr(req_addr), .req_autopre(req_autopre),
      .req_ready(req_ready), .init_done(init_done), .cmd_cs_n(cmd_cs_n),
      .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
      .cmd_ba(cmd_ba), .cmd_addr(cmd_addr));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, fails = 0, cyc = 0;
   string ctx = "R2";

   // reference model state
   int m_st = 0, m_wait = IW, m_mrd = 0, m_rp = 0, m_rc = 0, m_rcd = 0;
   bit [3:0] m_open = '0;
   bit last_acc = 0;

   function automatic logic [AW-1:0] base_word_exp();
      logic [AW-1:0] w = '0;
      w[2:0] = (BL == 2) ? 3'b001 : (BL == 4) ? 3'b010 : 3'b011;
      w[6:4] = (CLH == 4) ? 3'b010 : (CLH == 5) ? 3'b110 : 3'b011;
      return w;
   endfunction

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   function automatic int tdn(input int t, input bit ld, input int gap);
      if (ld) return (gap > 1) ? gap - 1 : 0;
      return (t > 0) ? t - 1 : 0;
   endfunction

   // one clock of the model; inputs already stable
   task automatic step();
      logic [2:0] ep = 3'b111;
      int eba = 0;
      logic [AW-1:0] ea = '0;
      bit rdy = 0, lmrd = 0, lrp = 0, lrc = 0, lrcd = 0;
      int nst = m_st;
      bit [3:0] nopen = m_open;
      string tag;
      #1;
      case (m_st)
         0: if (m_wait == 0) begin ep = 3'b010; ea[10] = 1'b1; lrp = 1; nopen = '0; nst = 1; end
         1: if (m_rp == 0 && m_mrd == 0) begin ep = 3'b000; eba = 1; lmrd = 1; nst = 2; end
         2: if (m_mrd == 0) begin ep = 3'b000; ea = base_word_exp(); lmrd = 1; nst = 3; end
         3: if (m_rp == 0 && m_mrd == 0 && m_rc == 0) begin ep = 3'b001; lrc = 1; nst = 4; end
         4: if (m_rc == 0) begin ep = 3'b001; lrc = 1; nst = 5; end
         default: begin
            case (req_op)
               3'd0: rdy = !m_open[req_bank] && m_rc == 0 && m_rp == 0;
               3'd1, 3'd2: rdy = m_open[req_bank] && m_rcd == 0;
               3'd3: rdy = 1;
               3'd4: rdy = (m_open == 0) && m_rc == 0 && m_rp == 0 && m_mrd == 0;
               default: rdy = 0;
            endcase
            if (req_valid && rdy) begin
               eba = req_bank;
               case (req_op)
                  3'd0: begin ep = 3'b011; ea = req_addr; nopen[req_bank] = 1; lrcd = 1; end
                  3'd1, 3'd2: begin
                     ep = (req_op == 3'd1) ? 3'b101 : 3'b100;
                     ea = req_addr; ea[10] = req_autopre;
                     if (req_autopre) begin nopen[req_bank] = 0; lrp = 1; end
                  end
                  3'd3: begin
                     ep = 3'b010; ea[10] = req_autopre; lrp = 1;
                     if (req_autopre) nopen = '0; else nopen[req_bank] = 0;
                  end
                  default: begin ep = 3'b001; eba = 0; lrc = 1; end
               endcase
            end
         end
      endcase
      chk((m_st == 5) ? ctx : "R12", "req_ready", req_ready, rdy);
      last_acc = req_valid && rdy;
      if (m_st == 0 && m_wait > 0) m_wait--;
      m_mrd = tdn(m_mrd, lmrd, TMRD);
      m_rp  = tdn(m_rp, lrp, TRP);
      m_rc  = tdn(m_rc, lrc, TRC);
      m_rcd = tdn(m_rcd, lrcd, TRCD);
      m_st = nst; m_open = nopen;
      @(posedge clk); @(negedge clk);
      tag = (ep == 3'b000) ? "R3" : (m_st < 5 || ep == 3'b111) ? ctx : "R11";
      chk("R1", "cs_n", cmd_cs_n, 0);
      chk(tag, "ras/cas/we", {cmd_ras_n, cmd_cas_n, cmd_we_n}, ep);
      chk(tag, "ba", cmd_ba, eba);
      chk((ep == 3'b010 || ep[2:1] == 2'b10) ? "R10" : tag, "addr", cmd_addr, ea);
      chk("R2", "init_done", init_done, m_st == 5);
   endtask

   task automatic req(input logic [2:0] op, input int bank, input int addr,
                      input bit ap, input int maxc, input bit want);
      bit got = 0;
      req_valid = 1; req_op = op; req_bank = bank[BW-1:0];
      req_addr = addr[AW-1:0]; req_autopre = ap;
      for (int i = 0; i < maxc && !got; i++) begin
         step();
         got = last_acc;
      end
      req_valid = 0;
      chk(ctx, "accepted", got, want);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         fails++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) begin
         @(negedge clk);
         chk("R1", "cs_n in reset", cmd_cs_n, 1);
         chk("R1", "pins in reset", {cmd_ras_n, cmd_cas_n, cmd_we_n}, 3'b111);
         chk("R1", "addr in reset", cmd_addr, 0);
         chk("R1", "init_done in reset", init_done, 0);
         chk("R1", "ready in reset", req_ready, 0);
      end
      rst_n = 1;
      // R12: request offered during initialization is ignored
      ctx = "R12";
      req_valid = 1; req_op = 3'd0; req_bank = 2'd0; req_addr = 12'h0AA;
      while (m_st != 5) step();
      req_valid = 0;
      chk("R2", "init_done after sequence", init_done, 1);
      ctx = "R6";  req(3'd0, 0, 'h123, 0, 20, 1);          // waits tRC after last refresh
      ctx = "R8";  req(3'd0, 0, 'h321, 0, 6, 0);           // bank 0 already open
                   req(3'd0, 1, 'h0F0, 0, 20, 1);
      ctx = "R7";  req(3'd1, 0, 'h045, 0, 20, 1);          // waits tRCD
      ctx = "R10"; req(3'd2, 1, 'h010, 1, 20, 1);          // write with auto-precharge closes bank 1
      ctx = "R8";  req(3'd1, 1, 'h011, 0, 4, 0);           // bank 1 now closed
      ctx = "R9";  req(3'd4, 0, 0, 0, 5, 0);               // bank 0 still open
      ctx = "R11"; req(3'd6, 0, 0, 0, 4, 0);               // unused op code
      ctx = "R10"; req(3'd3, 0, 0, 0, 5, 1);               // single-bank precharge
      ctx = "R5";  req(3'd4, 0, 0, 0, 20, 1);              // waits tRP
      ctx = "R6";  req(3'd4, 0, 0, 0, 20, 1);              // waits tRC
      ctx = "R4";  req(3'd0, 2, 'h7FF, 0, 20, 1);
      ctx = "R8";  req(3'd0, 3, 'h401, 0, 20, 1);
      ctx = "R7";  req(3'd2, 3, 'h4FF, 0, 20, 1);          // bit 10 forced low
      ctx = "R10"; req(3'd3, 1, 0, 1, 5, 1);               // precharge all
      ctx = "R9";  req(3'd1, 2, 'h001, 0, 4, 0);
      ctx = "R5";  req(3'd4, 0, 0, 0, 20, 1);
      ctx = "R5";  req(3'd0, 2, 'h055, 0, 20, 1);
      ctx = "R10"; req(3'd1, 2, 'h002, 1, 20, 1);          // read with auto-precharge
      ctx = "R5";  req(3'd0, 2, 'h066, 0, 20, 1);          // reopen after tRP
      ctx = "R11"; repeat (3) step();
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule